// File: doc/BRIEF.md
# Header-Check Cell Delineator

This block finds the boundaries of fixed-length transmission containers in a received byte stream. Each container holds a short header, one header-check byte and a payload. The block keeps its own byte position within the container it assumes. It runs a CRC-8 over the header bytes and compares the result with the check byte that follows them. A three-state machine (hunting, provisional, locked) turns the pass/fail outcome of each check into a locked flag. Separate programmable thresholds govern entry into lock and loss of lock.

While hunting, the block counts failed checks. After a set number of them it raises a one-cycle slip request and moves its assumed boundary one byte later by not counting the next accepted byte, so it steps through every alignment in turn. An optional coset can be folded into every expected check byte. Downstream logic uses the locked flag and the per-container good strobe to gate payload extraction.

Top module: `hec_cell_delineator`

## Requirements
- R1: A container is TC_LEN accepted bytes. The first byte accepted after reset is position 0. Bytes at positions 0 to HDR_LEN-1 form the header, and the byte at position HDR_LEN is the check byte. The check byte is correct when it equals the CRC-8 of the header bytes, with generator x^8+x^2+x+1, preset 0x00, most significant bit first. Cycles with in_valid low change nothing.
- R2: When coset_en is 1, the expected check byte is the CRC XOR 0x55. A check byte that lacks the coset then counts as erred.
- R3: hec_good is a single-cycle pulse in the cycle after a correct check byte is accepted. It stays low for an erred one.
- R4: In the hunting state, one correct check moves the machine to the provisional state.
- R5: In the provisional state, delta_thr consecutive correct checks move the machine to the locked state. Any erred check returns it to hunting.
- R6: In the locked state, alpha_thr consecutive erred checks return the machine to hunting. A correct check restarts that run.
- R7: A threshold input of zero selects the default value: 8 for entry (delta_thr) and 7 for loss (alpha_thr).
- R8: locked is 1 exactly while the machine is in the locked state. It changes in the cycle after the hec_good window of the deciding check.
- R9: While hunting, every SLIP_AFTER consecutive erred checks give a one-cycle slip_req pulse and restart the count. The next accepted byte is then not counted, so the assumed boundary moves one byte later. No slip occurs outside hunting.
- R10: After a synchronous active-low reset, locked, hec_good and slip_req are 0, and the machine is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Received byte |
| delta_thr | input | THR_W | Consecutive correct checks to enter lock (0 selects default) |
| alpha_thr | input | THR_W | Consecutive erred checks to lose lock (0 selects default) |
| coset_en | input | 1 | Fold 0x55 into every expected check byte |
| locked | output | 1 | Boundaries locked |
| hec_good | output | 1 | Pulse per correct check byte |
| slip_req | output | 1 | Pulse when the alignment is stepped by one byte |

## Verification
The bench builds the block with 12-byte containers, a 3-byte header and a slip after 3 failed checks. With these values a fully misaligned start realigns within a few dozen containers, so every starting offset can be reached in a short run. Entry and loss thresholds are driven between 1 and 4 in the random phase. They are driven at zero in one directed run, so the default values of 8 and 7 are crossed exactly. For misaligned runs, a periodic container template is screened so that no wrong offset can pass the check by chance. The expected slip count then equals the byte distance to the true boundary.

// File: rtl/celldel_pkg.sv
// Shared types and the header-check arithmetic for the cell delineator.
// Assumes byte-serial input, most significant bit first.
package celldel_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PRESYNC = 2'd1,
        ST_SYNC    = 2'd2
    } dl_state_e;

    localparam logic [7:0] HEC_COSET = 8'h55;
    localparam logic [7:0] HEC_POLY  = 8'h07;

    // Advance a CRC-8 (x^8+x^2+x+1) by one byte, MSB first.
    function automatic logic [7:0] hec_step(input logic [7:0] acc, input logic [7:0] din);
        logic [7:0] r;
        r = acc;
        for (int i = 7; i >= 0; i--) begin
            if (r[7] ^ din[i]) r = {r[6:0], 1'b0} ^ HEC_POLY;
            else               r = {r[6:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/celldel_slot.sv
// Byte position tracker within the assumed container.
// Counts accepted bytes modulo TC_LEN. A slip request (or one pending from
// an idle cycle) makes the next valid byte uncounted, which shifts the
// assumed boundary one byte later. Assumes TC_LEN >= HDR_LEN + 4, so a
// held byte always falls in the payload.
module celldel_slot #(
    parameter int TC_LEN  = 16,
    parameter int HDR_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic slip_req,
    output logic take,
    output logic at_first,
    output logic in_hdr,
    output logic at_hec
);
    localparam int PW = (TC_LEN > 2) ? $clog2(TC_LEN) : 1;
    localparam logic [PW-1:0] POS_LAST = PW'(TC_LEN - 1);
    localparam logic [PW-1:0] POS_HEC  = PW'(HDR_LEN);

    logic [PW-1:0] pos_q;
    logic          pend_q;
    logic          hold;

    assign hold     = slip_req | pend_q;
    assign take     = in_valid & ~hold;
    assign at_first = (pos_q == '0);
    assign in_hdr   = (pos_q < POS_HEC);
    assign at_hec   = (pos_q == POS_HEC);

    // Advance the position on counted bytes; remember a slip seen while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            pend_q <= 1'b0;
        end else if (in_valid) begin
            pend_q <= 1'b0;
            if (!hold) pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
        end else if (slip_req) begin
            pend_q <= 1'b1;
        end
    end

    // R1
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= POS_LAST);

    // R9
    slip_in_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip_req |-> (pos_q > POS_HEC));

endmodule

// File: rtl/celldel_hec.sv
// Header-check evaluator. Accumulates the CRC over header bytes and, at the
// check byte, registers one evaluation event with its pass/fail result.
// Assumes the slot tracker supplies the byte role and the take qualifier.
module celldel_hec
    import celldel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       at_first,
    input  logic       in_hdr,
    input  logic       at_hec,
    input  logic [7:0] in_byte,
    input  logic       coset_en,
    output logic       chk_evt,
    output logic       chk_ok
);
    logic [7:0] crc_q;
    logic [7:0] crc_base;
    logic [7:0] expect_hec;

    assign crc_base   = at_first ? 8'h00 : crc_q;
    assign expect_hec = crc_q ^ (coset_en ? HEC_COSET : 8'h00);

    // Fold each header byte into the running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n)                crc_q <= 8'h00;
        else if (take && in_hdr)   crc_q <= hec_step(crc_base, in_byte);
    end

    // Register one evaluation per check byte together with its verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_evt <= 1'b0;
            chk_ok  <= 1'b0;
        end else begin
            chk_evt <= take & at_hec;
            chk_ok  <= take & at_hec & (in_byte == expect_hec);
        end
    end

    // R3
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_evt |=> !chk_evt);

endmodule

// File: rtl/celldel_fsm.sv
// Delineation state machine. Consumes one check verdict per container and
// walks hunt -> presync -> sync with programmable entry/loss thresholds
// (zero selects the defaults). While hunting it counts failures and issues
// a one-cycle slip request every SLIP_AFTER of them.
module celldel_fsm
    import celldel_pkg::*;
#(
    parameter int THR_W      = 4,
    parameter int DELTA_DEF  = 8,
    parameter int ALPHA_DEF  = 7,
    parameter int SLIP_AFTER = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_evt,
    input  logic             chk_ok,
    input  logic [THR_W-1:0] delta_thr,
    input  logic [THR_W-1:0] alpha_thr,
    output logic             locked,
    output logic             slip_req
);
    localparam int FW = (SLIP_AFTER > 1) ? $clog2(SLIP_AFTER + 1) : 1;
    localparam logic [FW-1:0] MISS_LAST = FW'(SLIP_AFTER - 1);

    dl_state_e        state_q, state_d;
    logic [THR_W-1:0] run_q, run_d;
    logic [FW-1:0]    miss_q, miss_d;
    logic             slip_q, slip_d;
    logic [THR_W:0]   run_nxt;
    logic [THR_W:0]   delta_eff;
    logic [THR_W:0]   alpha_eff;

    assign run_nxt   = {1'b0, run_q} + 1'b1;
    assign delta_eff = (delta_thr == '0) ? (THR_W+1)'(DELTA_DEF) : {1'b0, delta_thr};
    assign alpha_eff = (alpha_thr == '0) ? (THR_W+1)'(ALPHA_DEF) : {1'b0, alpha_thr};
    assign locked    = (state_q == ST_SYNC);
    assign slip_req  = slip_q;

    // Next-state and counter update for one check verdict.
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        miss_d  = miss_q;
        slip_d  = 1'b0;
        if (chk_evt) begin
            case (state_q)
                ST_HUNT: begin
                    if (chk_ok) begin
                        state_d = ST_PRESYNC;
                        run_d   = '0;
                        miss_d  = '0;
                    end else if (miss_q == MISS_LAST) begin
                        miss_d = '0;
                        slip_d = 1'b1;
                    end else begin
                        miss_d = miss_q + 1'b1;
                    end
                end
                ST_PRESYNC: begin
                    if (!chk_ok) begin
                        state_d = ST_HUNT;
                        run_d   = '0;
                        miss_d  = '0;
                    end else if (run_nxt == delta_eff) begin
                        state_d = ST_SYNC;
                        run_d   = '0;
                    end else begin
                        run_d = run_nxt[THR_W-1:0];
                    end
                end
                ST_SYNC: begin
                    if (chk_ok) begin
                        run_d = '0;
                    end else if (run_nxt == alpha_eff) begin
                        state_d = ST_HUNT;
                        run_d   = '0;
                        miss_d  = '0;
                    end else begin
                        run_d = run_nxt[THR_W-1:0];
                    end
                end
                default: begin
                    state_d = ST_HUNT;
                    run_d   = '0;
                    miss_d  = '0;
                end
            endcase
        end
    end

    // State, counters and the slip pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            run_q   <= '0;
            miss_q  <= '0;
            slip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            miss_q  <= miss_d;
            slip_q  <= slip_d;
        end
    end

    // R5
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(chk_evt && chk_ok));

    // R5
    presync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRESYNC && chk_evt && !chk_ok) |=> (state_q == ST_HUNT));

    // R6
    lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(chk_evt && !chk_ok));

    // R6
    good_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && chk_evt && chk_ok) |=> locked);

    // R9
    slip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip_req |=> !slip_req);

    // R9
    slip_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip_req |-> !locked);

endmodule

// File: rtl/hec_cell_delineator.sv
// Top of the cell delineator: slot tracker, header-check evaluator and
// delineation state machine. Assumes TC_LEN >= HDR_LEN + 4 and a byte
// stream qualified by in_valid.
module hec_cell_delineator #(
    parameter int TC_LEN     = 16,
    parameter int HDR_LEN    = 4,
    parameter int THR_W      = 4,
    parameter int DELTA_DEF  = 8,
    parameter int ALPHA_DEF  = 7,
    parameter int SLIP_AFTER = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic [THR_W-1:0] delta_thr,
    input  logic [THR_W-1:0] alpha_thr,
    input  logic             coset_en,
    output logic             locked,
    output logic             hec_good,
    output logic             slip_req
);
    logic take, at_first, in_hdr, at_hec;
    logic chk_evt, chk_ok;

    celldel_slot #(
        .TC_LEN (TC_LEN),
        .HDR_LEN(HDR_LEN)
    ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .slip_req(slip_req),
        .take    (take),
        .at_first(at_first),
        .in_hdr  (in_hdr),
        .at_hec  (at_hec)
    );

    celldel_hec u_hec (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .at_first(at_first),
        .in_hdr  (in_hdr),
        .at_hec  (at_hec),
        .in_byte (in_byte),
        .coset_en(coset_en),
        .chk_evt (chk_evt),
        .chk_ok  (chk_ok)
    );

    celldel_fsm #(
        .THR_W     (THR_W),
        .DELTA_DEF (DELTA_DEF),
        .ALPHA_DEF (ALPHA_DEF),
        .SLIP_AFTER(SLIP_AFTER)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_evt  (chk_evt),
        .chk_ok   (chk_ok),
        .delta_thr(delta_thr),
        .alpha_thr(alpha_thr),
        .locked   (locked),
        .slip_req (slip_req)
    );

    assign hec_good = chk_evt & chk_ok;

    // R9
    good_slip_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hec_good |-> !slip_req);

endmodule

// File: tb/sim_hec_cell_delineator.sv
module sim_hec_cell_delineator;
    localparam int TB_TC   = 12;
    localparam int TB_HDR  = 3;
    localparam int TB_SLIP = 3;
    localparam int TW      = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic [TW-1:0] delta_thr = '0;
    logic [TW-1:0] alpha_thr = '0;
    logic          coset_en = 1'b0;
    wire           locked, hec_good, slip_req;

    always #2.5 clk = ~clk;

    hec_cell_delineator #(
        .TC_LEN(TB_TC), .HDR_LEN(TB_HDR), .THR_W(TW),
        .DELTA_DEF(8), .ALPHA_DEF(7), .SLIP_AFTER(TB_SLIP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .delta_thr(delta_thr), .alpha_thr(alpha_thr), .coset_en(coset_en),
        .locked(locked), .hec_good(hec_good), .slip_req(slip_req)
    );

    int total = 0, bad = 0;
    int gcount = 0, scount = 0;
    bit g_prev = 0, s_prev = 0;
    bit done = 0;
    int m_st = 0, m_run = 0, m_miss = 0;
    logic [7:0] tmpl [TB_TC];

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Bench CRC-8, x^8+x^2+x+1, preset zero, byte xor then 8 shifts.
    function automatic logic [7:0] tb_hec(input logic [7:0] w [TB_HDR]);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < TB_HDR; i++) begin
            c = c ^ w[i];
            for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    function automatic int eff(input logic [TW-1:0] thr, input int dflt);
        return (thr == 0) ? dflt : int'(thr);
    endfunction

    function automatic string st_tag(input int st);
        return (st == 0) ? "R4" : (st == 1) ? "R5" : "R6";
    endfunction

    function void model_step(input bit ok);
        case (m_st)
            0: if (ok) begin m_st = 1; m_run = 0; m_miss = 0; end
               else m_miss = (m_miss + 1 == TB_SLIP) ? 0 : m_miss + 1;
            1: if (!ok) begin m_st = 0; m_run = 0; m_miss = 0; end
               else if (m_run + 1 == eff(delta_thr, 8)) begin m_st = 2; m_run = 0; end
               else m_run++;
            default: if (ok) m_run = 0;
               else if (m_run + 1 == eff(alpha_thr, 7)) begin m_st = 0; m_run = 0; m_miss = 0; end
               else m_run++;
        endcase
    endfunction

    // Pulse counting and pulse-width checks, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hec_good) begin gcount++; check_eq("R3", "hec_good pulse width", int'(g_prev), 0); end
            if (slip_req) begin scount++; check_eq("R9", "slip pulse width", int'(s_prev), 0); end
        end
        g_prev = hec_good;
        s_prev = slip_req;
    end

    task automatic send_byte(input logic [7:0] b);
        int gap = int'($urandom_range(0, 3));
        if (gap > 1) begin
            repeat (gap - 1) begin
                in_valid = 1'b0;
                in_byte  = 8'($urandom);
                @(negedge clk);
            end
        end
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_run = 0; m_miss = 0;
        check_eq("R10", "locked after reset", int'(locked), 0);
        check_eq("R10", "hec_good after reset", int'(hec_good), 0);
        check_eq("R10", "slip_req after reset", int'(slip_req), 0);
    endtask

    task automatic send_tc(input bit corrupt, input bit drop_coset);
        logic [7:0] h [TB_HDR];
        logic [7:0] e;
        int g0 = gcount, s0 = scount;
        bit ok;
        string t;
        for (int i = 0; i < TB_HDR; i++) begin
            h[i] = 8'($urandom);
            send_byte(h[i]);
        end
        e = tb_hec(h);
        if (coset_en && !drop_coset) e = e ^ 8'h55;
        if (corrupt) e = e ^ 8'($urandom_range(1, 255));
        send_byte(e);
        for (int i = TB_HDR + 1; i < TB_TC; i++) send_byte(8'($urandom));
        ok = !corrupt && !(coset_en && drop_coset);
        t = (delta_thr == 0) ? "R7" : st_tag(m_st);
        model_step(ok);
        check_eq(coset_en ? "R2" : "R1", "hec_good pulses per container", gcount - g0, ok ? 1 : 0);
        check_eq({t, " R8"}, "locked", int'(locked), (m_st == 2) ? 1 : 0);
        check_eq("R9", "no slip while aligned", scount - s0, 0);
    endtask

    function automatic bit tmpl_clean(input logic [7:0] cz);
        logic [7:0] w [TB_HDR];
        for (int j = 1; j < TB_TC; j++) begin
            for (int i = 0; i < TB_HDR; i++) w[i] = tmpl[(j + i) % TB_TC];
            if ((tb_hec(w) ^ cz) == tmpl[(j + TB_HDR) % TB_TC]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic run_misalign(input int k, input int d, input bit cz);
        logic [7:0] w [TB_HDR];
        logic [7:0] cv;
        int s, s0;
        coset_en  = cz;
        delta_thr = TW'(d);
        alpha_thr = TW'(2);
        do_reset();
        cv = cz ? 8'h55 : 8'h00;
        do begin
            for (int i = 0; i < TB_TC; i++) tmpl[i] = 8'($urandom);
            for (int i = 0; i < TB_HDR; i++) w[i] = tmpl[i];
            tmpl[TB_HDR] = tb_hec(w) ^ cv;
        end while (!tmpl_clean(cv));
        s  = (TB_TC - k) % TB_TC;
        s0 = scount;
        for (int i = k; i < TB_TC; i++) send_byte(tmpl[i]);
        repeat (s * TB_SLIP + d + 4)
            for (int i = 0; i < TB_TC; i++) send_byte(tmpl[i]);
        check_eq("R9", "slips needed to realign", scount - s0, s);
        check_eq("R9", "locked after realign", int'(locked), 1);
    endtask

    initial begin
        bit seq1 [12] = '{0,0,1,0,0,0,0,1,0,1,1,0};
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // Thresholds 3/2: presync drop, lock, run restart, loss.
        delta_thr = 4'd3; alpha_thr = 4'd2; coset_en = 1'b0;
        do_reset();
        foreach (seq1[i]) send_tc(seq1[i], 1'b0);

        // Zero thresholds select defaults 8/7 (R7).
        delta_thr = '0; alpha_thr = '0;
        do_reset();
        repeat (9) send_tc(1'b0, 1'b0);
        repeat (6) send_tc(1'b1, 1'b0);
        send_tc(1'b0, 1'b0);
        repeat (6) send_tc(1'b1, 1'b0);
        send_tc(1'b1, 1'b0);

        // Coset on: plain check bytes count as erred, coset ones lock (R2).
        delta_thr = 4'd2; alpha_thr = 4'd2; coset_en = 1'b1;
        do_reset();
        repeat (2) send_tc(1'b0, 1'b1);
        repeat (3) send_tc(1'b0, 1'b0);

        // Misaligned starts exercise the slip walk (R9).
        run_misalign(5, 2, 1'b0);
        run_misalign(1, 1, 1'b1);
        run_misalign(11, 3, 1'b0);
        run_misalign(0, 2, 1'b0);

        // Constrained random aligned traffic.
        for (int blk = 0; blk < 4; blk++) begin
            delta_thr = TW'($urandom_range(1, 4));
            alpha_thr = TW'($urandom_range(1, 4));
            coset_en  = 1'($urandom_range(0, 1));
            do_reset();
            for (int n = 0; n < 20; n++) begin
                bit c = ($urandom_range(0, 3) == 0);
                if (m_st == 0 && m_miss == TB_SLIP - 1) c = 1'b0;
                send_tc(c, 1'b0);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule